// File: doc/BRIEF.md
# Drawing Command Word Receiver

This block sits between a host and a pixel drawing engine. The host places one packed 16-bit command on a parallel data bus and raises a valid strobe. The receiver takes the word on the first clock edge where it is free and armed. It splits the word into an opcode, a pen mode and an x,y coordinate, and it raises a one-cycle start pulse toward the engine.

Once it has taken a word, the receiver raises its busy line toward the host. Busy stays high for the whole time the engine needs to run the command, and only the engine's done pulse releases it. This is how the block holds off the host.

A host that keeps valid high after busy falls does not get the same command run twice. The receiver accepts nothing new until valid has been seen low for at least one clock.

Top module: `cmd_word_rx`

## Requirements
- R1: While reset is asserted (rst_n low), and on the first sample after it, busy and start are 0 and every decoded field is 0.
- R2: A word is captured on a rising clock edge where valid is 1, busy is 0 and the receiver is armed. After that edge, busy is 1 and start is 1.
- R3: The x output carries bits 5:0 of the captured word, and the y output carries bits 11:6.
- R4: The opcode output carries bits 15:14 unchanged, coded as follows: 00 move pen, 01 draw line, 10 clear screen, 11 flush cache.
- R5: The pen output is decoded from bits 13:12, coded as follows: 00 black gives 00, 01 white gives 01, 10 invert gives 10. The reserved code 11 gives white (01), so the pen output never shows 11.
- R6: While busy is 1 and done is 0, busy stays 1 and all decoded outputs hold their values. Any word offered with valid during this time is ignored.
- R7: A done pulse while busy is 0 has no effect. Busy stays 0 and no start is produced.
- R8: Busy falls on the edge where done is sampled 1 while busy is 1. After that, a valid held continuously high is not accepted. A new word is accepted only after valid has been sampled 0 on at least one edge.
- R9: Start is high for exactly one cycle per accepted command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_word | input | 16 | Packed command word from the host |
| host_valid | input | 1 | Host has a word on host_word |
| host_busy | output | 1 | Receiver is holding a command; host must wait |
| eng_done | input | 1 | Engine finished the current command (one-cycle pulse) |
| cmd_start | output | 1 | One-cycle pulse: new decoded command present |
| cmd_op | output | 2 | Decoded opcode |
| cmd_pen | output | 2 | Decoded pen mode |
| cmd_x | output | 6 | Decoded x coordinate |
| cmd_y | output | 6 | Decoded y coordinate |

## Verification
Random command words, with random engine latencies, are checked against a field-extraction function. These checks separate the coordinate slices from each other and from the opcode and pen bits.

Directed words step through every opcode and every pen code. This includes reserved pen 11 and all-ones coordinates, which expose a wrong bit slice or a missing reserved-pen mapping.

Other patterns test the handshake:
- New words are offered during busy, to show they are ignored.
- Done pulses are sent while idle.
- Valid is held high across the fall of busy, which separates a correct re-arm rule from one that would run a command twice.

// File: rtl/cmd_word_rx.sv
module cmd_word_rx #(
  parameter int COORD_W = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [2*COORD_W+3:0]   host_word,
  input  logic                   host_valid,
  output logic                   host_busy,
  input  logic                   eng_done,
  output logic                   cmd_start,
  output logic [1:0]             cmd_op,
  output logic [1:0]             cmd_pen,
  output logic [COORD_W-1:0]     cmd_x,
  output logic [COORD_W-1:0]     cmd_y
);
  localparam int Y_LO   = COORD_W;
  localparam int PEN_LO = 2 * COORD_W;
  localparam int OP_LO  = PEN_LO + 2;

  logic need_low;
  logic take;
  logic [1:0] pen_raw;
  logic [1:0] pen_dec;

  assign take    = host_valid && !host_busy && !need_low;
  assign pen_raw = host_word[PEN_LO +: 2];
  assign pen_dec = (pen_raw == 2'b11) ? 2'b01 : pen_raw;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_busy <= 1'b0;
      need_low  <= 1'b0;
      cmd_start <= 1'b0;
      cmd_op    <= '0;
      cmd_pen   <= '0;
      cmd_x     <= '0;
      cmd_y     <= '0;
    end else begin
      cmd_start <= take;
      if (take) begin
        host_busy <= 1'b1;
        cmd_op    <= host_word[OP_LO +: 2];
        cmd_pen   <= pen_dec;
        cmd_x     <= host_word[0 +: COORD_W];
        cmd_y     <= host_word[Y_LO +: COORD_W];
      end else if (host_busy && eng_done) begin
        host_busy <= 1'b0;
      end
      if (host_busy && eng_done)
        need_low <= 1'b1;
      else if (!host_valid)
        need_low <= 1'b0;
    end
  end
endmodule

module cmd_word_rx_chk #(
  parameter int COORD_W = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_valid,
  input logic               host_busy,
  input logic               eng_done,
  input logic               cmd_start,
  input logic [1:0]         cmd_op,
  input logic [1:0]         cmd_pen,
  input logic [COORD_W-1:0] cmd_x,
  input logic [COORD_W-1:0] cmd_y
);
  // R9
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |=> !cmd_start);
  // R2
  start_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_start |-> host_busy);
  // R2
  busy_rise_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy ##1 host_busy) |-> cmd_start);
  // R6
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && !eng_done) |=> host_busy);
  // R6
  fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && !eng_done) |=> ($stable(cmd_op) && $stable(cmd_pen) && $stable(cmd_x) && $stable(cmd_y)));
  // R7
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_busy && !host_valid) |=> !host_busy);
  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_busy && eng_done) |=> !host_busy);
  // R5
  always_comb begin
    if (rst_n) pen_code_chk: assert (cmd_pen != 2'b11);
  end
endmodule

bind cmd_word_rx cmd_word_rx_chk #(.COORD_W(COORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_valid(host_valid), .host_busy(host_busy),
  .eng_done(eng_done), .cmd_start(cmd_start), .cmd_op(cmd_op),
  .cmd_pen(cmd_pen), .cmd_x(cmd_x), .cmd_y(cmd_y)
);

// File: tb/cmd_word_rx_tb.sv
module cmd_word_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] host_word = '0;
  logic        host_valid = 1'b0;
  logic        host_busy;
  logic        eng_done = 1'b0;
  logic        cmd_start;
  logic [1:0]  cmd_op, cmd_pen;
  logic [5:0]  cmd_x, cmd_y;

  int n_chk = 0;
  int n_bad = 0;
  int seed;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cmd_word_rx u_dut (
    .clk(clk), .rst_n(rst_n), .host_word(host_word), .host_valid(host_valid),
    .host_busy(host_busy), .eng_done(eng_done), .cmd_start(cmd_start),
    .cmd_op(cmd_op), .cmd_pen(cmd_pen), .cmd_x(cmd_x), .cmd_y(cmd_y)
  );

  function automatic logic [15:0] exp_fields(input logic [15:0] w);
    logic [1:0] p;
    p = w[13:12];
    if (p == 2'b11) p = 2'b01;
    return {w[15:14], p, w[11:6], w[5:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w, input int lat, input bit hold);
    logic [15:0] e;
    e = exp_fields(w);
    host_word = w;
    host_valid = 1'b1;
    cyc();
    check("R2 busy", 32'(host_busy), 1);
    check("R2 start", 32'(cmd_start), 1);
    check("R4 op", 32'(cmd_op), 32'(e[15:14]));
    check("R5 pen", 32'(cmd_pen), 32'(e[13:12]));
    check("R3 x", 32'(cmd_x), 32'(e[5:0]));
    check("R3 y", 32'(cmd_y), 32'(e[11:6]));
    host_word = 16'(~w);
    for (int i = 0; i < lat; i++) begin
      cyc();
      check("R9 start", 32'(cmd_start), 0);
      check("R6 busy", 32'(host_busy), 1);
      check("R6 fields", {16'h0, cmd_op, cmd_pen, cmd_y, cmd_x}, 32'(e));
    end
    eng_done = 1'b1;
    cyc();
    eng_done = 1'b0;
    check("R8 release", 32'(host_busy), 0);
    if (hold) begin
      cyc();
      cyc();
      check("R8 no rearm", 32'(host_busy), 0);
      check("R8 no start", 32'(cmd_start), 0);
    end
    host_valid = 1'b0;
    cyc();
  endtask

  initial begin
    seed = 1234;
    void'($urandom(seed));
    cyc();
    check("R1 busy", 32'(host_busy), 0);
    check("R1 start", 32'(cmd_start), 0);
    check("R1 fields", {16'h0, cmd_op, cmd_pen, cmd_y, cmd_x}, 0);
    cyc();
    rst_n = 1'b1;
    cyc();
    check("R1 post", 32'(host_busy), 0);
    // R7: done while idle
    eng_done = 1'b1;
    cyc();
    eng_done = 1'b0;
    cyc();
    check("R7 busy", 32'(host_busy), 0);
    check("R7 start", 32'(cmd_start), 0);
    // R4 R5 directed opcodes and pens, including reserved pen
    for (int op = 0; op < 4; op++)
      for (int pn = 0; pn < 4; pn++)
        send({2'(op), 2'(pn), 6'h3F, 6'h3F}, 1, 1'b0);
    send(16'h0000, 0, 1'b1);
    send(16'h0FC0, 3, 1'b1);
    send(16'h003F, 2, 1'b0);
    for (int k = 0; k < 200; k++)
      send(16'($urandom), int'($urandom_range(0, 6)), bit'($urandom_range(0, 1)));
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule